// File: doc/BRIEF.md
# Capture/Compare Timer with Flag Clearing

This block holds a free-running up-counter whose step rate comes from a power-of-two prescaler, and a set of channels that each work either as an output compare or as an input capture. A compare channel raises its flag when the counter steps onto the value held in its data register. A capture channel synchronizes its input pin, watches for the selected edge, copies the counter into its data register and raises its flag. All channel flags live in one shared flag register, and each channel drives an interrupt line that is active while its flag and its enable bit are both set.

Software clears flags by writing ones to the flag register. Bits written as zero are left alone, so a read-modify-write of that register writes back every pending flag and clears all of them. A fast-clear control bit adds a second path: writing a compare channel's data register, or reading a capture channel's data register, clears that channel's flag.

The register port is a simple single-cycle bus. Reads return data combinationally while the strobe is high, and read side effects take place at the clock edge that ends the strobe cycle. Register offsets: 0 control, 1 channel mode, 2 capture edge select, 3 interrupt enable, 4 flags, 5 counter (read only), 8 plus n the data register of channel n.

Top module: `cct_timer`

## Requirements
- R1: After reset every register reads zero and every interrupt output is low.
- R2: The counter advances by exactly one on each prescaler tick while the run bit (control bit 0) is set, and holds its value while that bit is clear.
- R3: Control bits 3:1 hold a code n, and the counter then steps once every 2^n clock cycles (n=2 gives 10 steps in 40 cycles, n=7 gives 2 steps in 256 cycles).
- R4: A channel whose mode bit is 1 (compare) sets its flag on the clock edge at which the counter takes the value in its data register.
- R5: A channel whose mode bit is 0 (capture) latches the counter value and sets its flag on the third rising clock edge after its pin changes, on a rising pin edge when its edge-select bit is 1 and on a falling edge when it is 0; the other edge has no effect.
- R6: Writing the flag register (offset 4) clears exactly the flags whose bits are written as 1 and leaves the others as they were.
- R7: Reading the flag register and writing the value back with one more bit set clears every flag that was pending.
- R8: With the fast-clear bit (control bit 4) set, a write to a compare channel's data register clears that channel's flag only.
- R9: With the fast-clear bit set, a read of a capture channel's data register clears that channel's flag only.
- R10: With the fast-clear bit clear, reads and writes of the data registers leave all flags unchanged.
- R11: When a flag-set event and a clear of the same flag fall on the same clock edge, the flag ends up set.
- R12: Each interrupt output is high exactly when its channel's flag and its enable bit (offset 3, bit n) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe, triggers read side effects |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data, valid in the same cycle as the address |
| cap_in | input | NCH | Capture pins, one per channel, asynchronous |
| irq | output | NCH | Per-channel interrupt lines |

## Verification
The checks assume that a bus write and a bus read never target the same register in the same cycle, that strobes last a single cycle, and that a capture pin holds each level for at least three clock cycles so the synchronizer sees every edge. The stimulus drives all bus signals and pins half a cycle away from the active edge, issues one access at a time, and spaces pin changes four cycles or more apart. Capture tests run with the counter stopped so the latched value is known, and the same-edge set-and-clear case aligns a flag write exactly with the detected pin edge.

// File: rtl/cct_pkg.sv
`timescale 1ns/1ps
package cct_pkg;
   localparam int unsigned ADDR_W = 4;
   // register offsets on the bus
   localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
   localparam logic [ADDR_W-1:0] A_MODE = 4'd1;
   localparam logic [ADDR_W-1:0] A_EDGE = 4'd2;
   localparam logic [ADDR_W-1:0] A_IEN  = 4'd3;
   localparam logic [ADDR_W-1:0] A_FLAG = 4'd4;
   localparam logic [ADDR_W-1:0] A_CNT  = 4'd5;
   // channel data registers sit where bus_addr[3] is set
   localparam int unsigned CHAN_SEL_BIT = 3;
   localparam int unsigned MAX_CH = 8;
endpackage

// File: rtl/cct_prescaler.sv
`timescale 1ns/1ps
module cct_prescaler #(
   parameter int unsigned PS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [PS_W-1:0] sel,
   output logic            tick
);
   localparam int unsigned DIV_W = (1 << PS_W) - 1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;

   // low "sel" bits of the divider must all be one for a tick
   always_comb begin
      for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(sel));
   end

   assign tick = run && ((div_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   div_q <= '0;
      else if (run) div_q <= div_q + 1'b1;
   end
endmodule

// File: rtl/cct_channel.sv
`timescale 1ns/1ps
module cct_channel #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [CW-1:0] cnt_q,
   input  logic          cmp_mode,
   input  logic          rise_sel,
   input  logic          pin,
   input  logic          wr_hit,
   input  logic          rd_hit,
   input  logic [CW-1:0] wdata,
   input  logic          fast_clr,
   output logic [CW-1:0] data_q,
   output logic          set_evt,
   output logic          fclr
);
   logic sync0_q, sync1_q, prev_q;
   logic edge_ev, cap_ev, cmp_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync0_q <= 1'b0;
         sync1_q <= 1'b0;
         prev_q  <= 1'b0;
      end else begin
         sync0_q <= pin;
         sync1_q <= sync0_q;
         prev_q  <= sync1_q;
      end
   end

   assign edge_ev = rise_sel ? (sync1_q & ~prev_q) : (~sync1_q & prev_q);
   assign cap_ev  = !cmp_mode && edge_ev;
   // match when the counter is about to step onto the stored value
   assign cmp_ev  = cmp_mode && tick && (CW'(cnt_q + 1'b1) == data_q);
   assign set_evt = cap_ev | cmp_ev;
   assign fclr    = fast_clr && ((cmp_mode && wr_hit) || (!cmp_mode && rd_hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      data_q <= '0;
      else if (cap_ev) data_q <= cnt_q;
      else if (wr_hit) data_q <= wdata;
   end
endmodule

// File: rtl/cct_timer.sv
`timescale 1ns/1ps
module cct_timer
   import cct_pkg::*;
#(
   parameter int unsigned NCH          = 4,
   parameter int unsigned CW           = 16,
   parameter int unsigned PS_W         = 3,
   parameter bit          HAS_PRESCALE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CW-1:0]     bus_wdata,
   output logic [CW-1:0]     bus_rdata,
   input  logic [NCH-1:0]    cap_in,
   output logic [NCH-1:0]    irq
);
   localparam int unsigned FAST_BIT = PS_W + 1;
   localparam int unsigned CTRL_W   = PS_W + 2;

   if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
      $error("NCH must lie between 1 and MAX_CH");
   end
   if (CW < CTRL_W || CW < NCH) begin : g_bad_cw
      $error("CW too narrow for control or flag fields");
   end
   if (PS_W < 1 || PS_W > 4) begin : g_bad_ps
      $error("PS_W must lie between 1 and 4");
   end

   logic            run_q, fast_q, tick;
   logic [PS_W-1:0] ps_q;
   logic [NCH-1:0]  mode_q, edge_q, ien_q, flag_q;
   logic [CW-1:0]   cnt_q;
   logic [NCH-1:0]  set_vec, fclr_vec, w1c_vec;
   logic [CW-1:0]   chan_data [NCH];

   logic wr_ctrl, wr_mode, wr_edge, wr_ien, wr_flag;
   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
   assign wr_mode = bus_wr && (bus_addr == A_MODE);
   assign wr_edge = bus_wr && (bus_addr == A_EDGE);
   assign wr_ien  = bus_wr && (bus_addr == A_IEN);
   assign wr_flag = bus_wr && (bus_addr == A_FLAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         ps_q   <= '0;
         fast_q <= 1'b0;
         mode_q <= '0;
         edge_q <= '0;
         ien_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            run_q  <= bus_wdata[0];
            ps_q   <= bus_wdata[PS_W:1];
            fast_q <= bus_wdata[FAST_BIT];
         end
         if (wr_mode) mode_q <= bus_wdata[NCH-1:0];
         if (wr_edge) edge_q <= bus_wdata[NCH-1:0];
         if (wr_ien)  ien_q  <= bus_wdata[NCH-1:0];
      end
   end

   if (HAS_PRESCALE) begin : g_prescale
      cct_prescaler #(.PS_W(PS_W)) u_ps (
         .clk(clk), .rst_n(rst_n), .run(run_q), .sel(ps_q), .tick(tick)
      );
   end else begin : g_direct
      assign tick = run_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
   end

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic hit_wr, hit_rd;
      assign hit_wr = bus_wr && bus_addr[CHAN_SEL_BIT] && (bus_addr[CHAN_SEL_BIT-1:0] == 3'(g));
      assign hit_rd = bus_rd && bus_addr[CHAN_SEL_BIT] && (bus_addr[CHAN_SEL_BIT-1:0] == 3'(g));
      cct_channel #(.CW(CW)) u_ch (
         .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_q(cnt_q),
         .cmp_mode(mode_q[g]), .rise_sel(edge_q[g]), .pin(cap_in[g]),
         .wr_hit(hit_wr), .rd_hit(hit_rd), .wdata(bus_wdata),
         .fast_clr(fast_q), .data_q(chan_data[g]),
         .set_evt(set_vec[g]), .fclr(fclr_vec[g])
      );
   end

   assign w1c_vec = wr_flag ? bus_wdata[NCH-1:0] : '0;

   // a set event on the same edge overrides any clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~(w1c_vec | fclr_vec)) | set_vec;
   end

   assign irq = flag_q & ien_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr[CHAN_SEL_BIT]) begin
         for (int i = 0; i < NCH; i++)
            if (bus_addr[CHAN_SEL_BIT-1:0] == 3'(i)) bus_rdata = chan_data[i];
      end else begin
         case (bus_addr)
            A_CTRL: bus_rdata[CTRL_W-1:0] = {fast_q, ps_q, run_q};
            A_MODE: bus_rdata[NCH-1:0]    = mode_q;
            A_EDGE: bus_rdata[NCH-1:0]    = edge_q;
            A_IEN:  bus_rdata[NCH-1:0]    = ien_q;
            A_FLAG: bus_rdata[NCH-1:0]    = flag_q;
            A_CNT:  bus_rdata             = cnt_q;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cct_checker.sv
`timescale 1ns/1ps
module cct_checker
   import cct_pkg::*;
#(
   parameter int unsigned NCH = 4,
   parameter int unsigned CW  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_q,
   input logic [CW-1:0]     cnt_q,
   input logic [NCH-1:0]    flag_q,
   input logic [NCH-1:0]    set_vec,
   input logic [NCH-1:0]    ien_q,
   input logic [NCH-1:0]    irq,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [CW-1:0]     bus_wdata
);
   a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> $stable(cnt_q));

   a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt_q == $past(cnt_q)) || (cnt_q == CW'($past(cnt_q) + 1'b1)));

   a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

   a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_FLAG) |=> ((flag_q & $past(bus_wdata[NCH-1:0] & ~set_vec)) == '0));

   a_r4_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(set_vec)) == '0));

   a_r12_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (irq & ~ien_q) == '0);
endmodule

bind cct_timer cct_checker #(.NCH(NCH), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_q(run_q), .cnt_q(cnt_q), .flag_q(flag_q),
   .set_vec(set_vec), .ien_q(ien_q), .irq(irq), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/cct_timer_bench.sv
`timescale 1ns/1ps
module cct_timer_bench;
   localparam int NCH = 4;
   localparam int CW  = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]     bus_addr = '0;
   logic [CW-1:0]  bus_wdata = '0;
   logic [CW-1:0]  bus_rdata;
   logic [NCH-1:0] cap_in = '0;
   logic [NCH-1:0] irq;

   int total = 0, bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cct_timer #(.NCH(NCH), .CW(CW)) u_cct_timer (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cap_in(cap_in), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [CW-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [CW-1:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // look at a side-effect-free register in the current cycle
   task automatic peek(input logic [3:0] a, output logic [CW-1:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [CW-1:0] v;
      rd(4'd0, v); chk("R1 ctrl", v, 0);
      rd(4'd4, v); chk("R1 flags", v, 0);
      rd(4'd8, v); chk("R1 ch0 data", v, 0);
      chk("R1 irq", irq, 0);
      wait_neg(5);
      peek(4'd5, v); chk("R2 counter holds when stopped", v, 0);
   endtask

   task automatic t_compare;
      logic [CW-1:0] v, c0;
      wr(4'd8, 16'd3);
      wr(4'd1, 16'h1);
      wr(4'd3, 16'h1);
      wr(4'd0, 16'h1);        // run, divide by 1
      wait_neg(2);
      chk("R4 no flag before match", irq, 0);
      @(negedge clk);
      chk("R4 flag on match edge", irq, 4'b0001);
      peek(4'd5, v); chk("R4 counter at compare value", v, 3);
      wr(4'd0, 16'h0);
      peek(4'd5, c0);
      wait_neg(6);
      peek(4'd5, v); chk("R2 counter frozen after stop", v, c0);
      wr(4'd4, 16'hF);
      peek(4'd4, v); chk("R6 full clear", v, 0);
   endtask

   task automatic t_prescale;
      logic [CW-1:0] c0, c1;
      wr(4'd0, 16'h5);        // run, code 2
      @(negedge clk); peek(4'd5, c0);
      wait_neg(40); peek(4'd5, c1);
      chk("R3 divide by 4", c1 - c0, 10);
      wr(4'd0, 16'hF);        // run, code 7
      @(negedge clk); peek(4'd5, c0);
      wait_neg(256); peek(4'd5, c1);
      chk("R3 divide by 128", c1 - c0, 2);
      wr(4'd0, 16'h0);
      wr(4'd4, 16'hF);
   endtask

   task automatic t_capture;
      logic [CW-1:0] v, base;
      wr(4'd1, 16'h0);        // all capture
      wr(4'd2, 16'h2);        // ch1 rising, others falling
      wr(4'd3, 16'h4);
      wr(4'd4, 16'hF);
      @(negedge clk); peek(4'd5, base);
      cap_in[1] = 1'b1;
      wait_neg(2);
      peek(4'd4, v); chk("R5 not yet captured", v, 0);
      @(negedge clk);
      peek(4'd4, v); chk("R5 rising capture flag", v, 4'b0010);
      rd(4'd9, v); chk("R5 ch1 captured value", v, base);
      peek(4'd4, v); chk("R10 read without fast clear keeps flag", v, 4'b0010);
      cap_in[2] = 1'b1;
      wait_neg(4);
      peek(4'd4, v); chk("R5 wrong edge ignored", v, 4'b0010);
      cap_in[2] = 1'b0;
      wait_neg(4);
      peek(4'd4, v); chk("R5 falling capture flag", v, 4'b0110);
      rd(4'd10, v); chk("R5 ch2 captured value", v, base);
      chk("R12 irq gated by enable", irq, 4'b0100);
   endtask

   task automatic t_w1c;
      logic [CW-1:0] v, f;
      wr(4'd4, 16'h2);
      peek(4'd4, v); chk("R6 single bit clear", v, 4'b0100);
      cap_in[3] = 1'b1; wait_neg(4);
      cap_in[3] = 1'b0; wait_neg(4);
      rd(4'd4, f); chk("R7 two flags pending", f, 4'b1100);
      wr(4'd4, f | 16'h1);
      peek(4'd4, v); chk("R7 read-modify-write clears all", v, 0);
      chk("R12 irq drops with flag", irq, 0);
   endtask

   task automatic t_fast;
      logic [CW-1:0] v;
      wr(4'd2, 16'h3);        // ch0 and ch1 rising
      wr(4'd3, 16'h2);
      cap_in[1] = 1'b0; wait_neg(4);
      cap_in[0] = 1'b1; cap_in[1] = 1'b1; wait_neg(4);
      peek(4'd4, v); chk("R5 two rising captures", v, 4'b0011);
      chk("R12 irq only where enabled", irq, 4'b0010);
      wr(4'd1, 16'h1);        // ch0 becomes compare
      wr(4'd8, 16'h1234);
      peek(4'd4, v); chk("R10 write without fast clear keeps flag", v, 4'b0011);
      wr(4'd0, 16'h10);       // fast clear on, stopped
      wr(4'd8, 16'h4321);
      peek(4'd4, v); chk("R8 compare write clears own flag", v, 4'b0010);
      rd(4'd8, v); chk("R8 compare data written", v, 16'h4321);
      rd(4'd9, v);
      peek(4'd4, v); chk("R9 capture read clears own flag", v, 0);
      wr(4'd0, 16'h0);
   endtask

   task automatic t_setwins;
      logic [CW-1:0] v;
      cap_in[1] = 1'b0; wait_neg(4);
      peek(4'd4, v); chk("R5 falling ignored on rising channel", v, 0);
      cap_in[1] = 1'b1;
      wait_neg(2);
      bus_wr = 1'b1; bus_addr = 4'd4; bus_wdata = 16'h2;
      @(negedge clk);
      bus_wr = 1'b0;
      peek(4'd4, v); chk("R11 set beats same-edge clear", v, 4'b0010);
      wr(4'd4, 16'h2);
      peek(4'd4, v); chk("R6 later clear works", v, 0);
   endtask

   initial begin
      wait_neg(3);
      rst_n = 1'b1;
      t_reset();
      t_compare();
      t_prescale();
      t_capture();
      t_w1c();
      t_fast();
      t_setwins();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule